// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block runs entirely in the bit-clock domain. It turns a serial audio stream back into parallel stereo samples. It watches a left-right clock and a serial data line, and rebuilds one left sample and one right sample per left-right period. Three framings are supported: left-justified, right-justified and I2S. Four word lengths are supported: 16, 20, 24 and 32 bits. Both the framing and the word length come from static configuration inputs. In every framing the most significant bit arrives first.

A finished word is presented left-aligned in a 32-bit output with zeros below it, together with a one-cycle valid strobe for its channel. The strobe fires on the rising bit-clock edge where the receiver sees that the channel's phase has ended. The duty cycle of the left-right clock is free, as long as each level lasts at least one word length of bit clocks. An error flag reports an illegal configuration or a phase that is too short.

Top module: `stereo_serial_rx`

## Requirements
- R1: With fmtSel = 0 (left-justified), the word's MSB is taken on the first rising bitClk edge after a lrClk change, and the next word-length bits follow in order. lrClk high carries the left channel and lrClk low carries the right channel.
- R2: With fmtSel = 2 (I2S), the MSB is taken on the second rising bitClk edge after a lrClk change, one bit later than in R1. lrClk low carries the left channel. A phase exactly one word long is accepted, and its last bit is then sampled in the first slot of the following phase.
- R3: With fmtSel = 1 (right-justified), the LSB is taken on the last rising bitClk edge before the lrClk change. The word is the last word-length bits of the phase. lrClk high carries the left channel.
- R4: lenSel selects the word length: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits. The received word is placed in bits 31 down to 32-length of the output, and all lower bits are zero. Extra bits in a phase have no effect on the word: in R1 and R2 these are the bits after the word, and in R3 they are the bits before it.
- R5: A word is delivered at the first rising edge of the next phase (R1, R3) or at the second rising edge (R2). Delivery sets the channel's word output and raises its valid for exactly one cycle. leftValid and rightValid are never high together.
- R6: Phases of any length from the word length up to well beyond it are accepted, in any mix of high and low durations.
- R7: A phase shorter than the word length raises errFlag for one cycle, in the cycle its strobe would have fired. That phase's valid is suppressed and its word output keeps its previous value. Following legal phases are received normally.
- R8: fmtSel = 3, or fmtSel = 1 with lenSel = 3 (32-bit right-justified), is illegal. While it is applied, errFlag is held high and no valid strobe fires.
- R9: After reset, both words are zero, both valids and errFlag are low, and the partial phase that runs before the first lrClk change produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low reset, synchronous to bitClk |
| lrClk | input | 1 | Left-right clock marking channel phases |
| serIn | input | 1 | Serial audio data, MSB first |
| fmtSel | input | 2 | Framing: 0 left-justified, 1 right-justified, 2 I2S, 3 illegal |
| lenSel | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| leftWord | output | 32 | Last left sample, left-aligned, zero filled |
| rightWord | output | 32 | Last right sample, left-aligned, zero filled |
| leftValid | output | 1 | One-cycle strobe when leftWord is updated |
| rightValid | output | 1 | One-cycle strobe when rightWord is updated |
| errFlag | output | 1 | Illegal configuration (level) or short phase (pulse) |

## Verification
The edge that closes a phase does two jobs at once. It delivers the finished word, and it judges whether the phase was long enough. The bench sends a right phase shorter than the word length, between legal phases. On that edge the error pulse must be counted, and no right strobe and no change of rightWord may appear. The next phases must then be delivered cleanly. The I2S sweep also uses phases exactly one word long. In that case the last data bit and the phase boundary fall on the same edge, and the bench checks the word value and the exact slot of its strobe.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'd0,
    FMT_RIGHT = 2'd1,
    FMT_I2S   = 2'd2,
    FMT_RSVD  = 2'd3
  } fmtT;

  typedef struct packed {
    logic startWord;
    logic shiftBit;
    logic loadLeft;
    logic loadRight;
  } rxStrobeT;

  function automatic logic [6:0] lenBits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7'd16;
      2'd1:    return 7'd20;
      2'd2:    return 7'd24;
      default: return 7'd32;
    endcase
  endfunction

endpackage

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import audio_rx_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lrClk,
  input  logic [1:0] fmtSel,
  input  logic [1:0] lenSel,
  output rxStrobeT strobe,
  output logic     errOut
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic lrDly, lrUsePrev, inPhase, errReg;
  logic [1:0] warm;
  logic [CNT_W-1:0] cnt, idx, wlen;
  logic isI2s, isRj, cfgBad, lrUse, isEdge, shortPh, deliver;

  always_comb begin
    isI2s   = (fmtT'(fmtSel) == FMT_I2S);
    isRj    = (fmtT'(fmtSel) == FMT_RIGHT);
    cfgBad  = (fmtT'(fmtSel) == FMT_RSVD) || (isRj && lenSel == 2'd3);
    wlen    = CNT_W'(lenBits(lenSel));
    // I2S is left-justified framing with a one-bit-late, inverted LR clock
    lrUse   = isI2s ? ~lrDly : lrClk;
    isEdge  = (warm == 2'd2) && (lrUse != lrUsePrev);
    idx     = isEdge ? '0 : cnt;
    shortPh = (cnt < wlen);
    deliver = isEdge && inPhase && !cfgBad && !shortPh;
    strobe.loadLeft  = deliver && lrUsePrev;
    strobe.loadRight = deliver && !lrUsePrev;
    strobe.startWord = isEdge && !isRj;
    strobe.shiftBit  = isRj || (idx < wlen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lrDly     <= 1'b0;
      lrUsePrev <= 1'b0;
      warm      <= 2'd0;
      inPhase   <= 1'b0;
      cnt       <= '0;
      errReg    <= 1'b0;
    end else begin
      lrDly     <= lrClk;
      lrUsePrev <= lrUse;
      if (warm != 2'd2) warm <= warm + 2'd1;
      if (isEdge) inPhase <= 1'b1;
      if (isEdge)               cnt <= CNT_W'(1);
      else if (cnt != CNT_MAX)  cnt <= cnt + CNT_W'(1);
      errReg <= cfgBad || (isEdge && inPhase && shortPh);
    end
  end

  assign errOut = errReg;

endmodule

// File: rtl/rx_word_dpath.sv
module rx_word_dpath
  import audio_rx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic [1:0]        lenSel,
  input  rxStrobeT          strobe,
  output logic [DATA_W-1:0] leftWord,
  output logic [DATA_W-1:0] rightWord,
  output logic              leftValid,
  output logic              rightValid
);

  logic [DATA_W-1:0] capReg, aligned;
  logic [6:0] shiftAmt;

  always_comb begin
    shiftAmt = 7'(DATA_W) - lenBits(lenSel);
    aligned  = capReg << shiftAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg     <= '0;
      leftWord   <= '0;
      rightWord  <= '0;
      leftValid  <= 1'b0;
      rightValid <= 1'b0;
    end else begin
      if (strobe.startWord)     capReg <= {{(DATA_W-1){1'b0}}, serIn};
      else if (strobe.shiftBit) capReg <= {capReg[DATA_W-2:0], serIn};
      leftValid  <= strobe.loadLeft;
      rightValid <= strobe.loadRight;
      if (strobe.loadLeft)  leftWord  <= aligned;
      if (strobe.loadRight) rightWord <= aligned;
    end
  end

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    !(leftValid && rightValid)); // R5
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (leftValid || rightValid) |=> !(leftValid || rightValid)); // R5
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !leftValid |-> $stable(leftWord)); // R7

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import audio_rx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              lrClk,
  input  logic              serIn,
  input  logic [1:0]        fmtSel,
  input  logic [1:0]        lenSel,
  output logic [DATA_W-1:0] leftWord,
  output logic [DATA_W-1:0] rightWord,
  output logic              leftValid,
  output logic              rightValid,
  output logic              errFlag
);

  localparam int CNT_W = $clog2(DATA_W) + 2;

  rxStrobeT strobe;

  rx_frame_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(bitClk), .rstN(rstN), .lrClk(lrClk), .fmtSel(fmtSel),
    .lenSel(lenSel), .strobe(strobe), .errOut(errFlag)
  );

  rx_word_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(bitClk), .rstN(rstN), .serIn(serIn), .lenSel(lenSel),
    .strobe(strobe), .leftWord(leftWord), .rightWord(rightWord),
    .leftValid(leftValid), .rightValid(rightValid)
  );

  AST_ERR_BLOCKS_VALID: assert property (@(posedge bitClk) disable iff (!rstN)
    errFlag |-> !(leftValid || rightValid)); // R7
  AST_BADCFG_SILENT: assert property (@(posedge bitClk) disable iff (!rstN)
    (fmtSel == 2'd3) |=> (errFlag && !leftValid && !rightValid)); // R8
  AST_ZERO_FILL: assert property (@(posedge bitClk) disable iff (!rstN)
    (leftValid && lenSel == 2'd0 && $past(lenSel) == 2'd0) |-> (leftWord[15:0] == 16'd0)); // R4

endmodule

// File: tb/tb_stereo_serial_rx.sv
`timescale 1ns/1ps
module tb_stereo_serial_rx;

  logic bitClk = 1'b0;
  logic rstN, lrClk, serIn;
  logic [1:0] fmtSel, lenSel;
  logic [31:0] leftWord, rightWord;
  logic leftValid, rightValid, errFlag;

  stereo_serial_rx dut (
    .bitClk(bitClk), .rstN(rstN), .lrClk(lrClk), .serIn(serIn),
    .fmtSel(fmtSel), .lenSel(lenSel), .leftWord(leftWord), .rightWord(rightWord),
    .leftValid(leftValid), .rightValid(rightValid), .errFlag(errFlag)
  );

  always #2.5 bitClk = ~bitClk;

  int tests = 0, fails = 0, slotNum = 0;
  int lCnt, rCnt, eCnt, lSlot, rSlot;
  logic [31:0] lWord, rWord;
  logic carry;
  bit done = 0;

  always @(posedge bitClk) begin
    #1;
    if (rstN === 1'b1) begin
      if (leftValid)  begin lCnt++; lWord = leftWord;  lSlot = slotNum; end
      if (rightValid) begin rCnt++; rWord = rightWord; rSlot = slotNum; end
      if (errFlag) eCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic ljBit(input logic [31:0] val, input int wlen, input int i);
    return (i < wlen) ? val[wlen-1-i] : 1'b1;
  endfunction

  function automatic int wlenOf(input logic [1:0] s);
    return 16 + 4 * int'(s) + ((s == 2'd3) ? 4 : 0);
  endfunction

  function automatic logic [31:0] alignExp(input logic [31:0] val, input int wlen);
    logic [63:0] m;
    m = (64'd1 << wlen) - 64'd1;
    return 32'(((64'(val) & m) << (32 - wlen)));
  endfunction

  // returns the slot number of the phase's first slot
  task automatic sendPhase(input bit isLeft, input logic [31:0] val, input int n, output int startSlot);
    int wlen;
    wlen = wlenOf(lenSel);
    for (int i = 0; i < n; i++) begin
      @(negedge bitClk);
      lrClk = (fmtSel == 2'd2) ? !isLeft : isLeft;
      if (fmtSel == 2'd1)      serIn = (i >= n - wlen) ? val[n-1-i] : 1'b1;
      else if (fmtSel == 2'd2) serIn = (i == 0) ? carry : ljBit(val, wlen, i - 1);
      else                     serIn = ljBit(val, wlen, i);
      slotNum++;
      if (i == 0) startSlot = slotNum;
    end
    carry = ljBit(val, wlen, n - 1);
  endtask

  task automatic doReset(input logic [1:0] fmt, input logic [1:0] len);
    rstN = 1'b0; fmtSel = fmt; lenSel = len;
    lrClk = (fmt == 2'd2) ? 1'b1 : 1'b0;  // level opposite to the first (left) phase
    serIn = 1'b0; carry = 1'b0;
    repeat (3) @(negedge bitClk);
    rstN = 1'b1;
    lCnt = 0; rCnt = 0; eCnt = 0; lWord = 0; rWord = 0;
    repeat (4) @(negedge bitClk);
  endtask

  task automatic runCfg(input logic [1:0] fmt, input logic [1:0] len);
    int wlen, n, st, prevSt, expL, expR;
    logic [31:0] val, prevVal;
    string tag;
    bit prevLeft;
    tag = (fmt == 2'd0) ? "R1 R4 R6" : (fmt == 2'd1) ? "R3 R4 R6" : "R2 R4 R6";
    doReset(fmt, len);
    wlen = wlenOf(len);
    expL = 0; expR = 0; prevVal = 0; prevSt = 0; prevLeft = 0;
    for (int p = 0; p < 7; p++) begin
      n = (p == 2 || p == 5) ? wlen : wlen + ((p * 7 + int'(len)) % 13);
      val = 32'h9E37_79B9 * 32'(p + 1 + int'(fmt) * 8 + int'(len) * 3) ^ 32'h5A5A_3C3C;
      sendPhase((p % 2) == 0, val, n, st);
      if (p == 0)
        check((lCnt + rCnt) == 0, "R9 partial phase", 32'(lCnt + rCnt), 32'd0);
      else if (prevLeft) begin
        expL++;
        check(lCnt == expL, "R5 left count", 32'(lCnt), 32'(expL));
        check(lWord == alignExp(prevVal, wlen), {tag, " left word"}, lWord, alignExp(prevVal, wlen));
        check(lSlot == st + ((fmt == 2'd2) ? 1 : 0), "R5 left slot", 32'(lSlot), 32'(st + ((fmt == 2'd2) ? 1 : 0)));
      end else begin
        expR++;
        check(rCnt == expR, "R5 right count", 32'(rCnt), 32'(expR));
        check(rWord == alignExp(prevVal, wlen), {tag, " right word"}, rWord, alignExp(prevVal, wlen));
        check(rSlot == st + ((fmt == 2'd2) ? 1 : 0), "R5 right slot", 32'(rSlot), 32'(st + ((fmt == 2'd2) ? 1 : 0)));
      end
      check(eCnt == 0, "R6 no error", 32'(eCnt), 32'd0);
      prevVal = val; prevSt = st; prevLeft = (p % 2) == 0;
    end
  endtask

  initial begin
    int st;
    // R9 reset state
    doReset(2'd0, 2'd0);
    check(leftWord == 0 && rightWord == 0, "R9 words", leftWord | rightWord, 32'd0);
    check(!leftValid && !rightValid && !errFlag, "R9 flags",
          {29'd0, leftValid, rightValid, errFlag}, 32'd0);

    for (int f = 0; f < 3; f++)
      for (int l = 0; l < 4; l++)
        if (!(f == 1 && l == 3)) runCfg(2'(f), 2'(l));

    // R7 short phase
    doReset(2'd0, 2'd0);
    sendPhase(1'b1, 32'h0000_A5C3, 20, st);
    sendPhase(1'b0, 32'h0000_1234, 10, st);
    check(lWord == 32'hA5C3_0000, "R7 left before short", lWord, 32'hA5C3_0000);
    sendPhase(1'b1, 32'h0000_0F0F, 18, st);
    check(rCnt == 0, "R7 short strobe suppressed", 32'(rCnt), 32'd0);
    check(eCnt == 1, "R7 error pulse", 32'(eCnt), 32'd1);
    check(rightWord == 32'd0, "R7 word held", rightWord, 32'd0);
    sendPhase(1'b0, 32'h0000_BEEF, 16, st);
    check(lWord == 32'h0F0F_0000 && lCnt == 2, "R7 recovery left", lWord, 32'h0F0F_0000);
    sendPhase(1'b1, 32'h0000_0001, 16, st);
    check(rWord == 32'hBEEF_0000 && rCnt == 1, "R7 recovery right", rWord, 32'hBEEF_0000);

    // R8 illegal configurations
    for (int k = 0; k < 2; k++) begin
      if (k == 0) doReset(2'd3, 2'd0); else doReset(2'd1, 2'd3);
      for (int p = 0; p < 4; p++) sendPhase((p % 2) == 0, 32'hCAFE_F00D, 40, st);
      check((lCnt + rCnt) == 0, "R8 no strobes", 32'(lCnt + rCnt), 32'd0);
      check(errFlag == 1'b1, "R8 error level", {31'd0, errFlag}, 32'd1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule